// File: doc/BRIEF.md
# Single-Channel DMA Engine

This block moves a programmed number of words between a device data port and memory, without the processor touching each word. Software loads a word address and a word count, then writes the control word with its go bit set. The engine then asks for the memory bus. It moves one word in every cycle in which the bus is granted and the device is ready. After each word it steps the address up by one and the count down by one.

When the count reaches zero the engine releases the bus and raises a completion flag. If the interrupt enable was set, it also latches an interrupt. Software clears both by writing the control word with the completion bit at 0. Two bus occupancy policies can be chosen. In cycle-stealing mode the engine lets go of the bus for one cycle after every word, so the processor gets gaps to use it. In burst mode it keeps the request raised from the first word to the last.

Top module: `dma_chan`

## Requirements
- R1: After reset, every register reads 0, `busReq`, `irq`, `memWe`, `memEn`, `devWrStb` and `devRdStb` are low, and `memAddr` is 0.
- R2: `regRdata` shows the register chosen by `regSel`. Select 0 is the word address and select 1 is the remaining count, both zero-extended. Select 2 is the control word: bit 0 is the direction, bit 1 the interrupt enable, bit 3 burst mode, bit 29 busy, bit 30 the interrupt flag and bit 31 done. The go bit (bit 2) and all other bits read 0, and select 3 reads 0.
- R3: A control write with bit 2 set, made while the engine is idle and the count is nonzero, makes busy and `busReq` go high on the next cycle. With a zero count, the go bit starts nothing.
- R4: A word moves in a cycle where `busReq`, `busGnt` and `devReady` are all high; `memEn` marks that cycle. With direction 1 (memory to device), `devWrStb` pulses and `devWrData` equals `memRdata` read at `memAddr`. With direction 0, `memWe` and `devRdStb` pulse and `memWdata` equals `devRdData`.
- R5: Each moved word adds 1 to the address and takes 1 from the count, as the next cycle's register reads show.
- R6: In cycle-stealing mode (bit 3 = 0), `busReq` is low for exactly one cycle after each word except the last, and then comes back.
- R7: In burst mode (bit 3 = 1), `busReq` stays high from the cycle after the go write until the final word, even while the grant or the device stalls.
- R8: The word that brings the count to zero ends the transfer: on the next cycle busy and `busReq` are low and done is set.
- R9: At completion the interrupt flag and the `irq` pin are set only if the interrupt enable is 1. `irq` stays high until software clears it.
- R10: An idle control write with bit 31 = 0 clears done, the interrupt flag and `irq`. With bit 31 = 1 it leaves them unchanged.
- R11: While busy, writes to the address, count and control registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select for reads and writes |
| regWr | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Selected register contents |
| busReq | output | 1 | Memory bus request |
| busGnt | input | 1 | Memory bus grant |
| memEn | output | 1 | Memory access in this cycle |
| memWe | output | 1 | Memory write in this cycle |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Data written to memory |
| memRdata | input | DATA_W | Data read from memory (same cycle) |
| devReady | input | 1 | Device can supply or accept a word |
| devRdData | input | DATA_W | Word offered by the device |
| devRdStb | output | 1 | Device word consumed |
| devWrData | output | DATA_W | Word sent to the device |
| devWrStb | output | 1 | Device word delivered |
| irq | output | 1 | Interrupt request |

## Verification
A wrong address or count is visible at `memAddr` in the very next word cycle, and on register reads one cycle after the word. A wrong sequencer state has two visible effects. It can leave `busReq` high during a cycle-stealing gap, or drop it in the middle of a burst; either shows on the cycle after a word. It can also end a transfer one word early or late, which shows up as a mismatch in done, busy and `irq`. Because the bench compares every output against its model on every clock, each such fault is reported in the cycle where it first reaches a port.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_GAP    = 2'd2
  } dmaState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic busy;
    logic start;
    logic xfer;
    logic last;
  } dmaStrobe_t;

  localparam int REG_W     = 32;
  localparam int DIR_BIT   = 0;
  localparam int IE_BIT    = 1;
  localparam int GO_BIT    = 2;
  localparam int BURST_BIT = 3;
  localparam int BUSY_BIT  = 29;
  localparam int IRQ_BIT   = 30;
  localparam int DONE_BIT  = 31;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       goReq,
  input  logic       cntZero,
  input  logic       cntOne,
  input  logic       burstMode,
  input  logic       busGnt,
  input  logic       devReady,
  output dmaStrobe_t strb,
  output logic       busReq
);

  dmaState_e stateQ, stateD;

  always_comb begin
    busReq      = (stateQ == ST_ACTIVE);
    strb.busy   = (stateQ != ST_IDLE);
    strb.start  = (stateQ == ST_IDLE) && goReq && !cntZero;
    strb.xfer   = busReq && busGnt && devReady;
    strb.last   = strb.xfer && cntOne;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (strb.start) stateD = ST_ACTIVE;
      ST_ACTIVE: begin
        if (strb.last)      stateD = ST_IDLE;
        else if (strb.xfer) stateD = burstMode ? ST_ACTIVE : ST_GAP;
      end
      ST_GAP:    stateD = ST_ACTIVE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R6: cycle-stealing leaves a one-cycle hole after each non-final word
  p_steal_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.xfer && !strb.last && !burstMode) |=> !busReq);

  // R6: the hole lasts one cycle only
  p_steal_resume_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_GAP) |=> busReq);

  // R7: burst keeps the request
  p_burst_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !strb.last && burstMode) |=> busReq);

  // R8: final word releases the bus
  p_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.last |=> (!busReq && !strb.busy));

  // R3: go with nonzero count raises the request next cycle
  p_start_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> busReq);

endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strb,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              goReq,
  output logic              cntZero,
  output logic              cntOne,
  output logic              burstMode,
  output logic              dirRead,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] devRdData,
  output logic [DATA_W-1:0] devWrData,
  output logic              irq
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  cntQ;
  logic              dirQ, ieQ, burstQ, doneQ, irqQ;
  logic              cpuWr;

  assign cpuWr     = regWr && !strb.busy;
  assign goReq     = regWr && (regSel == SEL_CTRL) && regWdata[GO_BIT];
  assign cntZero   = (cntQ == '0);
  assign cntOne    = (cntQ == CNT_ONE);
  assign burstMode = burstQ;
  assign dirRead   = dirQ;
  assign memAddr   = addrQ;
  assign memWdata  = devRdData;
  assign devWrData = memRdata;
  assign irq       = irqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      cntQ  <= '0;
    end else if (strb.xfer) begin
      addrQ <= addrQ + ADDR_W'(1);
      cntQ  <= cntQ - CNT_ONE;
    end else if (cpuWr && regSel == SEL_ADDR) begin
      addrQ <= regWdata[ADDR_W-1:0];
    end else if (cpuWr && regSel == SEL_COUNT) begin
      cntQ  <= regWdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ   <= 1'b0;
      ieQ    <= 1'b0;
      burstQ <= 1'b0;
      doneQ  <= 1'b0;
      irqQ   <= 1'b0;
    end else if (strb.last) begin
      doneQ <= 1'b1;
      irqQ  <= ieQ;
    end else if (cpuWr && regSel == SEL_CTRL) begin
      dirQ   <= regWdata[DIR_BIT];
      ieQ    <= regWdata[IE_BIT];
      burstQ <= regWdata[BURST_BIT];
      doneQ  <= doneQ && regWdata[DONE_BIT];
      irqQ   <= irqQ && regWdata[DONE_BIT];
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_ADDR:  regRdata[ADDR_W-1:0] = addrQ;
      SEL_COUNT: regRdata[CNT_W-1:0]  = cntQ;
      SEL_CTRL: begin
        regRdata[DIR_BIT]   = dirQ;
        regRdata[IE_BIT]    = ieQ;
        regRdata[BURST_BIT] = burstQ;
        regRdata[BUSY_BIT]  = strb.busy;
        regRdata[IRQ_BIT]   = irqQ;
        regRdata[DONE_BIT]  = doneQ;
      end
      default: regRdata = '0;
    endcase
  end

  // R5: each moved word takes one from the count
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.xfer |=> (cntQ == $past(cntQ) - CNT_ONE));

  // R5: and adds one to the address
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.xfer |=> (addrQ == $past(addrQ) + ADDR_W'(1)));

  // R9: interrupt flag only alongside done
  p_irq_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> doneQ);

  // R11: no CPU effect on the address or mode while busy
  p_frozen_r11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busy && !strb.xfer) |=> ($stable(addrQ) && $stable(cntQ) && $stable(burstQ) && $stable(dirQ)));

  // R8: completion sets done
  p_done_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.last |=> (doneQ && cntZero));

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              busReq,
  input  logic              busGnt,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              devReady,
  input  logic [DATA_W-1:0] devRdData,
  output logic              devRdStb,
  output logic [DATA_W-1:0] devWrData,
  output logic              devWrStb,
  output logic              irq
);

  dmaStrobe_t strb;
  logic goReq, cntZero, cntOne, burstMode, dirRead;

  dma_chan_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .goReq     (goReq),
    .cntZero   (cntZero),
    .cntOne    (cntOne),
    .burstMode (burstMode),
    .busGnt    (busGnt),
    .devReady  (devReady),
    .strb      (strb),
    .busReq    (busReq)
  );

  dma_chan_dp #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regSel    (regSel),
    .regWr     (regWr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .goReq     (goReq),
    .cntZero   (cntZero),
    .cntOne    (cntOne),
    .burstMode (burstMode),
    .dirRead   (dirRead),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memRdata  (memRdata),
    .devRdData (devRdData),
    .devWrData (devWrData),
    .irq       (irq)
  );

  assign memEn    = strb.xfer;
  assign memWe    = strb.xfer && !dirRead;
  assign devRdStb = strb.xfer && !dirRead;
  assign devWrStb = strb.xfer && dirRead;

  // R4: at most one side of the device port moves per cycle
  p_dev_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({devRdStb, devWrStb}));

  // R4: a word moves only under a granted request
  p_xfer_granted_r4: assert property (@(posedge clk) disable iff (!rstN)
    memEn |-> (busReq && busGnt && devReady));

endmodule

// File: tb/sim_dma_chan.sv
module sim_dma_chan;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        busReq, busGnt = 1'b0;
  logic        memEn, memWe;
  logic [15:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic        devReady = 1'b0;
  logic [31:0] devRdData = '0;
  logic        devRdStb, devWrStb;
  logic [31:0] devWrData;
  logic        irq;

  logic [31:0] mem [0:255];
  assign memRdata = mem[memAddr[7:0]];

  always #10 clk = ~clk;  // 50 MHz

  dma_chan u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .busReq(busReq), .busGnt(busGnt), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .devReady(devReady),
    .devRdData(devRdData), .devRdStb(devRdStb), .devWrData(devWrData), .devWrStb(devWrStb),
    .irq(irq)
  );

  int vectors = 0;
  int miscompares = 0;

  // reference model state
  int          mSt = 0;  // 0 idle, 1 active, 2 gap
  logic [15:0] mAddr = '0;
  logic [15:0] mCnt = '0;
  logic        mDir = 0, mIe = 0, mBurst = 0, mDone = 0, mIrq = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [1:0] s);
    logic [31:0] v = '0;
    case (s)
      2'd0: v[15:0] = mAddr;
      2'd1: v[15:0] = mCnt;
      2'd2: begin
        v[0] = mDir; v[1] = mIe; v[3] = mBurst;
        v[29] = (mSt != 0); v[30] = mIrq; v[31] = mDone;
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  // one clock: compare before the edge, then advance the model
  task automatic cyc();
    bit eReq, eX;
    logic [31:0] rdExp;
    #5;
    vectors++;
    eReq = (mSt == 1);
    eX = eReq && busGnt && devReady;
    rdExp = expRead(regSel);
    chk(regRdata === rdExp, "R2", "regRdata", regRdata, rdExp);
    chk(busReq === eReq, (mBurst ? "R7" : "R6"), "busReq", 32'(busReq), 32'(eReq));
    chk(irq === mIrq, "R9", "irq", 32'(irq), 32'(mIrq));
    chk(memAddr === mAddr, "R5", "memAddr", 32'(memAddr), 32'(mAddr));
    chk(memEn === eX, "R4", "memEn", 32'(memEn), 32'(eX));
    chk(memWe === (eX && !mDir), "R4", "memWe", 32'(memWe), 32'(eX && !mDir));
    chk(devRdStb === (eX && !mDir), "R4", "devRdStb", 32'(devRdStb), 32'(eX && !mDir));
    chk(devWrStb === (eX && mDir), "R4", "devWrStb", 32'(devWrStb), 32'(eX && mDir));
    if (eX && !mDir) chk(memWdata === devRdData, "R4", "memWdata", memWdata, devRdData);
    if (eX && mDir)  chk(devWrData === mem[mAddr[7:0]], "R4", "devWrData", devWrData, mem[mAddr[7:0]]);
    @(posedge clk);
    if (memWe) mem[memAddr[7:0]] = memWdata;
    if (regWr && mSt == 0) begin
      case (regSel)
        2'd0: mAddr = regWdata[15:0];
        2'd1: mCnt = regWdata[15:0];
        2'd2: begin
          mDir = regWdata[0]; mIe = regWdata[1]; mBurst = regWdata[3];
          mDone = mDone && regWdata[31];
          mIrq = mIrq && regWdata[31];
          if (regWdata[2] && mCnt != 0) mSt = 1;
        end
        default: ;
      endcase
    end else if (mSt == 1 && eX) begin
      mAddr = mAddr + 16'd1;
      mCnt = mCnt - 16'd1;
      if (mCnt == 0) begin
        mSt = 0; mDone = 1; mIrq = mIe;
      end else begin
        mSt = mBurst ? 1 : 2;
      end
    end else if (mSt == 2) begin
      mSt = 1;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    regSel = s; regWr = 1'b1; regWdata = d;
    cyc();
    regWr = 1'b0; regWdata = '0;
  endtask

  // run n cycles; stall picks a random grant/ready pattern, reads rotate
  task automatic run(input int n, input bit stall);
    for (int k = 0; k < n; k++) begin
      regSel = 2'(k % 4);
      busGnt = stall ? ($urandom % 4 != 0) : 1'b1;
      devReady = stall ? ($urandom % 3 != 0) : 1'b1;
      devRdData = $urandom;
      cyc();
    end
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + i;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state, all selects read back
    run(8, 0);

    // R3: go with zero count starts nothing
    wr(2'd2, 32'h0000_0004);
    regSel = 2'd2; cyc();

    // R2, R5, R6, R9: device to memory, cycle stealing, IE on
    wr(2'd0, 32'h0000_0010);
    wr(2'd1, 32'h0000_0004);
    wr(2'd2, 32'h0000_0006);
    // R11: writes while busy are ignored
    wr(2'd0, 32'h0000_0077);
    wr(2'd1, 32'h0000_0009);
    wr(2'd2, 32'h0000_000B);
    run(30, 1);
    // R10: writing bit 31 as 1 keeps done and irq, as 0 clears them
    wr(2'd2, 32'h8000_0002);
    regSel = 2'd2; cyc();
    wr(2'd2, 32'h0000_0002);
    regSel = 2'd2; cyc();

    // R7, R8, R9: memory to device, burst, IE off, stalls
    wr(2'd0, 32'h0000_0010);
    wr(2'd1, 32'h0000_0005);
    wr(2'd2, 32'h0000_000D);
    run(40, 1);

    // R7: burst with a clean grant
    wr(2'd0, 32'h0000_0040);
    wr(2'd1, 32'h0000_0003);
    wr(2'd2, 32'h0000_000E);
    run(10, 0);

    // R8: single-word transfer, cycle stealing, device to memory
    wr(2'd2, 32'h0000_0002);
    wr(2'd0, 32'h0000_00F0);
    wr(2'd1, 32'h0000_0001);
    wr(2'd2, 32'h0000_0006);
    run(6, 0);

    // R6: long cycle-stealing run with stalls
    wr(2'd0, 32'h0000_0080);
    wr(2'd1, 32'h0000_000C);
    wr(2'd2, 32'h0000_0005);
    run(80, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule